// File: doc/BRIEF.md
# Ethernet receive destination-address filter

This block decides, for each arriving Ethernet frame, whether the frame is kept or dropped. It looks at the six destination-address bytes and the final frame length. From these it classifies the frame as unicast, broadcast or multicast. It applies a size check, a basic address stage and an optional extended stage, and returns a registered verdict one cycle after the request. It also flags frames that pass every filter but are too short to be valid.

The basic stage holds one station address and four multicast entries, and it can be bypassed with a promiscuous bit. The extended stage has its own station address and a 32768-bit multicast hash table, and it applies even in promiscuous mode. Configuration is loaded through a simple register write port, and the table through a separate word-write port. Frame storage and checksums are handled elsewhere.

Top module: `rx_addr_filter`

## Requirements
- R1: Each verdict carries exactly one class flag. The frame is unicast when bit 0 of destination byte 0 is 0 and broadcast when all six bytes are 0xFF; any other frame is multicast. Byte k of the address is `dest_addr_i[8k+7:8k]`.
- R2: When `req_valid_i` is high in a cycle, `dec_valid_o` is high in the next cycle with that frame's verdict. When `req_valid_i` is low, `dec_valid_o` is low in the next cycle.
- R3: Unless promiscuous mode (MASK bit 31) is set, a unicast frame is dropped when its address differs from the station pair. Bytes 0..3 are compared with UC_LO in little-endian order (byte 0 = bits 7:0), and bytes 4..5 with UC_HI bits 15:0.
- R4: A broadcast frame is dropped when CTL bit 2 is set. This holds in the basic stage and also, when the extended stage is active, regardless of promiscuous mode.
- R5: Unless promiscuous mode is set, a multicast frame is dropped when CTL bit 1 is set or when its address matches none of the four multicast entries. The entries use the same byte order as R3.
- R6: A write to MC_LO or MC_HI updates only the multicast entry selected by MASK bits 1:0.
- R7: The extended stage is active only when both CTL bit 11 and CTL bit 12 are set. While it is active, a unicast frame is dropped unless it matches the XUC_LO/XUC_HI pair, even in promiscuous mode.
- R8: In the extended stage, a multicast frame whose bytes 0..2 are 01-00-52 is dropped. Any other multicast frame forms the 15-bit index {byte4[6:0], byte5} and is dropped when bit index[4:0] of table word index[14:5] is clear. The table is written per 32-bit word through the `tbl_*` port.
- R9: When both CTL bit 13 (jumbo) and CTL bit 14 (tagged) are clear, a frame of length 1519 to 1522 is dropped without a reject flag. Lengths 1518 and 1523 are not affected by this rule.
- R10: A frame shorter than 12 bytes that passes every filter gives `reject_o`=1 and `accept_o`=0. A short frame that a filter drops gives `reject_o`=0.
- R11: All configuration resets to zero. A register write takes effect for a request presented in the cycle after the write. The select codes are CTL=0, MASK=1, UC_LO=2, UC_HI=3, XUC_LO=4, XUC_HI=5, MC_LO=6 and MC_HI=7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| tbl_we_i | input | 1 | Hash table word write strobe |
| tbl_waddr_i | input | 10 | Hash table word address |
| tbl_wdata_i | input | 32 | Hash table word data |
| req_valid_i | input | 1 | Frame descriptor valid |
| dest_addr_i | input | 48 | Destination address, byte 0 in bits 7:0 |
| frame_len_i | input | 16 | Final frame length in bytes |
| dec_valid_o | output | 1 | Verdict valid |
| accept_o | output | 1 | Frame kept |
| reject_o | output | 1 | Short frame passed filters but rejected |
| ucast_o | output | 1 | Unicast class |
| bcast_o | output | 1 | Broadcast class |
| mcast_o | output | 1 | Multicast class |

## Verification
A corrupted configuration field or multicast entry shows as a wrong `accept_o` on the first frame whose class and address depend on it. That verdict appears in the cycle after the request. A wrongly written or wrongly indexed table word only shows when a multicast address hashing to that word arrives with the extended stage enabled. For that reason the sweep fills every word with a computed pattern and crosses every control-bit combination with each address class and with lengths at the 12, 1518 and 1522 edges.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [2:0] {
    SEL_CTL    = 3'd0,
    SEL_MASK   = 3'd1,
    SEL_UC_LO  = 3'd2,
    SEL_UC_HI  = 3'd3,
    SEL_XUC_LO = 3'd4,
    SEL_XUC_HI = 3'd5,
    SEL_MC_LO  = 3'd6,
    SEL_MC_HI  = 3'd7
  } cfg_sel_e;

  localparam int CTL_MC_REJ  = 1;
  localparam int CTL_BC_REJ  = 2;
  localparam int CTL_EXT_A   = 11;
  localparam int CTL_EXT_B   = 12;
  localparam int CTL_JUMBO   = 13;
  localparam int CTL_TAGGED  = 14;
  localparam int MASK_PROMISC = 31;

  typedef struct packed {
    logic        mc_rej;
    logic        bc_rej;
    logic        ext_en;
    logic        jumbo_en;
    logic        tagged_en;
    logic        promisc;
    logic [31:0] uc_lo;
    logic [15:0] uc_hi;
    logic [31:0] xuc_lo;
    logic [15:0] xuc_hi;
  } rxf_cfg_t;

  function automatic logic addr_hit(input logic [47:0] a,
                                    input logic [31:0] lo,
                                    input logic [15:0] hi);
    return a == {hi, lo};
  endfunction

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int MC_ENTRIES = 4,
  parameter int SEL_W      = (MC_ENTRIES > 1) ? $clog2(MC_ENTRIES) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [2:0]                   sel_i,
  input  logic [31:0]                  wdata_i,
  output rxf_cfg_t                     cfg_o,
  output logic [MC_ENTRIES-1:0][31:0]  mc_lo_o,
  output logic [MC_ENTRIES-1:0][15:0]  mc_hi_o
);

  logic [SEL_W-1:0] ent_sel_q;
  logic             ext_a_q, ext_b_q;
  rxf_cfg_t         cfg_q;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      ent_sel_q <= '0;
      ext_a_q   <= 1'b0;
      ext_b_q   <= 1'b0;
    end else if (we_i) begin
      unique case (cfg_sel_e'(sel_i))
        SEL_CTL: begin
          cfg_q.mc_rej    <= wdata_i[CTL_MC_REJ];
          cfg_q.bc_rej    <= wdata_i[CTL_BC_REJ];
          ext_a_q         <= wdata_i[CTL_EXT_A];
          ext_b_q         <= wdata_i[CTL_EXT_B];
          cfg_q.jumbo_en  <= wdata_i[CTL_JUMBO];
          cfg_q.tagged_en <= wdata_i[CTL_TAGGED];
        end
        SEL_MASK: begin
          cfg_q.promisc <= wdata_i[MASK_PROMISC];
          ent_sel_q     <= wdata_i[SEL_W-1:0];
        end
        SEL_UC_LO:  cfg_q.uc_lo  <= wdata_i;
        SEL_UC_HI:  cfg_q.uc_hi  <= wdata_i[15:0];
        SEL_XUC_LO: cfg_q.xuc_lo <= wdata_i;
        SEL_XUC_HI: cfg_q.xuc_hi <= wdata_i[15:0];
        default: ;
      endcase
    end
  end

  // both enable bits must be set for the second stage
  always_comb begin
    cfg_o        = cfg_q;
    cfg_o.ext_en = ext_a_q & ext_b_q;
  end

  for (genvar g = 0; g < MC_ENTRIES; g++) begin : g_ent
    logic [31:0] lo_q;
    logic [15:0] hi_q;
    logic        hit_sel;
    assign hit_sel = (ent_sel_q == SEL_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (we_i && hit_sel) begin
        if (sel_i == SEL_MC_LO) lo_q <= wdata_i;
        if (sel_i == SEL_MC_HI) hi_q <= wdata_i[15:0];
      end
    end
    assign mc_lo_o[g] = lo_q;
    assign mc_hi_o[g] = hi_q;
  end

  // R6: entry write lands in the selected slot
  a_r6_mc_lo_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_MC_LO && 32'(ent_sel_q) < MC_ENTRIES)
      |=> mc_lo_o[$past(ent_sel_q)] == $past(wdata_i));

endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table #(
  parameter int TBL_IDX_W = 15,
  parameter int AW        = TBL_IDX_W - 5
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [31:0]   wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [31:0]   rdata_o
);

  localparam int WORDS = 1 << AW;

  logic [31:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
  import rxf_pkg::*;
#(
  parameter int MC_ENTRIES = 4,
  parameter int LEN_W      = 16,
  parameter int TBL_IDX_W  = 15,
  parameter int AW         = TBL_IDX_W - 5,
  parameter int STD_MAX    = 1518,
  parameter int TAG_MAX    = 1522,
  parameter int MIN_LEN    = 12
) (
  input  logic [47:0]                  dest_i,
  input  logic [LEN_W-1:0]             len_i,
  input  rxf_cfg_t                     cfg_i,
  input  logic [MC_ENTRIES-1:0][31:0]  mc_lo_i,
  input  logic [MC_ENTRIES-1:0][15:0]  mc_hi_i,
  output logic [AW-1:0]                tbl_raddr_o,
  input  logic [31:0]                  tbl_word_i,
  output logic                         is_uc_o,
  output logic                         is_bc_o,
  output logic                         is_mc_o,
  output logic                         accept_o,
  output logic                         reject_o
);

  localparam logic [LEN_W-1:0] STD_MAX_L = LEN_W'(STD_MAX);
  localparam logic [LEN_W-1:0] TAG_MAX_L = LEN_W'(TAG_MAX);
  localparam logic [LEN_W-1:0] MIN_LEN_L = LEN_W'(MIN_LEN);
  localparam logic [23:0]      IP_PFX    = 24'h520001;

  logic                  uc, bc, mc;
  logic [MC_ENTRIES-1:0] mc_hit;
  logic [15:0]           hash_raw;
  logic [TBL_IDX_W-1:0]  hash_idx;
  logic                  tbl_bit, ip_pfx;
  logic                  size_drop, basic_drop, ext_drop, filtered, short_len;
  logic                  unused_hash;

  assign uc = ~dest_i[0];
  assign bc = &dest_i;
  assign mc = ~uc & ~bc;

  for (genvar g = 0; g < MC_ENTRIES; g++) begin : g_hit
    assign mc_hit[g] = addr_hit(dest_i, mc_lo_i[g], mc_hi_i[g]);
  end

  assign hash_raw    = {1'b0, dest_i[38:32], dest_i[47:40]};
  assign hash_idx    = hash_raw[TBL_IDX_W-1:0];
  assign unused_hash = ^hash_raw;
  assign tbl_raddr_o = hash_idx[TBL_IDX_W-1:5];
  assign tbl_bit     = tbl_word_i[hash_idx[4:0]];
  assign ip_pfx      = (dest_i[23:0] == IP_PFX);

  assign size_drop = ~cfg_i.jumbo_en & ~cfg_i.tagged_en
                   & (len_i > STD_MAX_L) & (len_i <= TAG_MAX_L);

  assign basic_drop = ~cfg_i.promisc &
    ((uc & ~addr_hit(dest_i, cfg_i.uc_lo, cfg_i.uc_hi)) |
     (bc & cfg_i.bc_rej) |
     (mc & (cfg_i.mc_rej | ~(|mc_hit))));

  assign ext_drop = cfg_i.ext_en &
    ((uc & ~addr_hit(dest_i, cfg_i.xuc_lo, cfg_i.xuc_hi)) |
     (bc & cfg_i.bc_rej) |
     (mc & (ip_pfx | ~tbl_bit)));

  assign filtered  = size_drop | basic_drop | ext_drop;
  assign short_len = len_i < MIN_LEN_L;

  assign is_uc_o  = uc;
  assign is_bc_o  = bc;
  assign is_mc_o  = mc;
  assign accept_o = ~filtered & ~short_len;
  assign reject_o = ~filtered & short_len;

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int MC_ENTRIES = 4,
  parameter int LEN_W      = 16,
  parameter int TBL_IDX_W  = 15,
  parameter int STD_MAX    = 1518,
  parameter int TAG_MAX    = 1522,
  parameter int MIN_LEN    = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [2:0]              cfg_sel_i,
  input  logic [31:0]             cfg_wdata_i,
  input  logic                    tbl_we_i,
  input  logic [TBL_IDX_W-6:0]    tbl_waddr_i,
  input  logic [31:0]             tbl_wdata_i,
  input  logic                    req_valid_i,
  input  logic [47:0]             dest_addr_i,
  input  logic [LEN_W-1:0]        frame_len_i,
  output logic                    dec_valid_o,
  output logic                    accept_o,
  output logic                    reject_o,
  output logic                    ucast_o,
  output logic                    bcast_o,
  output logic                    mcast_o
);

  localparam int AW = TBL_IDX_W - 5;

  rxf_cfg_t                    cfg;
  logic [MC_ENTRIES-1:0][31:0] mc_lo;
  logic [MC_ENTRIES-1:0][15:0] mc_hi;
  logic [AW-1:0]               tbl_raddr;
  logic [31:0]                 tbl_word;
  logic                        c_uc, c_bc, c_mc, c_acc, c_rej;

  rxf_cfg_regs #(.MC_ENTRIES(MC_ENTRIES)) i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .mc_lo_o (mc_lo),
    .mc_hi_o (mc_hi)
  );

  rxf_hash_table #(.TBL_IDX_W(TBL_IDX_W), .AW(AW)) i_tbl (
    .clk_i   (clk_i),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_waddr_i),
    .wdata_i (tbl_wdata_i),
    .raddr_i (tbl_raddr),
    .rdata_o (tbl_word)
  );

  rxf_classify #(
    .MC_ENTRIES (MC_ENTRIES),
    .LEN_W      (LEN_W),
    .TBL_IDX_W  (TBL_IDX_W),
    .AW         (AW),
    .STD_MAX    (STD_MAX),
    .TAG_MAX    (TAG_MAX),
    .MIN_LEN    (MIN_LEN)
  ) i_cls (
    .dest_i      (dest_addr_i),
    .len_i       (frame_len_i),
    .cfg_i       (cfg),
    .mc_lo_i     (mc_lo),
    .mc_hi_i     (mc_hi),
    .tbl_raddr_o (tbl_raddr),
    .tbl_word_i  (tbl_word),
    .is_uc_o     (c_uc),
    .is_bc_o     (c_bc),
    .is_mc_o     (c_mc),
    .accept_o    (c_acc),
    .reject_o    (c_rej)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o <= 1'b0;
      accept_o    <= 1'b0;
      reject_o    <= 1'b0;
      ucast_o     <= 1'b0;
      bcast_o     <= 1'b0;
      mcast_o     <= 1'b0;
    end else begin
      dec_valid_o <= req_valid_i;
      accept_o    <= req_valid_i & c_acc;
      reject_o    <= req_valid_i & c_rej;
      ucast_o     <= req_valid_i & c_uc;
      bcast_o     <= req_valid_i & c_bc;
      mcast_o     <= req_valid_i & c_mc;
    end
  end

  // R2: verdict follows request by one cycle
  a_r2_dec_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> dec_valid_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !dec_valid_o);
  // R1: one class per verdict
  a_r1_one_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> $countones({ucast_o, bcast_o, mcast_o}) == 1);
  // R10: reject only for short frames, never with accept
  a_r10_reject_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (!reject_o || (!accept_o &&
      32'($past(frame_len_i)) < MIN_LEN)));
  // R9: oversize-window frames never accepted without jumbo/tagged
  a_r9_size_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !cfg.jumbo_en && !cfg.tagged_en &&
     32'(frame_len_i) > STD_MAX && 32'(frame_len_i) <= TAG_MAX)
      |=> (!accept_o && !reject_o));

endmodule

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
  import rxf_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        tbl_we_i = 1'b0;
  logic [9:0]  tbl_waddr_i = '0;
  logic [31:0] tbl_wdata_i = '0;
  logic        req_valid_i = 1'b0;
  logic [47:0] dest_addr_i = '0;
  logic [15:0] frame_len_i = '0;
  logic dec_valid_o, accept_o, reject_o, ucast_o, bcast_o, mcast_o;

  int n_cmp = 0;
  int n_bad = 0;

  // bench-side shadow of configuration
  logic        m_mcrej, m_bcrej, m_exta, m_extb, m_jumbo, m_tag, m_prom;
  logic [31:0] m_uclo = '0, m_xuclo = '0;
  logic [15:0] m_uchi = '0, m_xuchi = '0;
  logic [31:0] m_mclo [4];
  logic [15:0] m_mchi [4];
  logic [1:0]  m_sel;

  always #4 clk_i = ~clk_i;

  rx_addr_filter i_rx_addr_filter (.*);

  function automatic logic [31:0] tbl_pat(input int w);
    logic [31:0] x;
    x = 32'(w) * 32'h9E3779B1;
    return x ^ (32'(w) << 7) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [47:0] mc_addr(input int k);
    logic [23:0] lo;
    lo = (k == 3) ? 24'h520001 : 24'h5E0001;
    return {8'(8'h20 + k * 8'h13), 8'(8'h40 + k), 8'(k), lo};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] sel, input logic [31:0] d);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    case (sel)
      3'd0: begin
        m_mcrej = d[1]; m_bcrej = d[2]; m_exta = d[11]; m_extb = d[12];
        m_jumbo = d[13]; m_tag = d[14];
      end
      3'd1: begin m_prom = d[31]; m_sel = d[1:0]; end
      3'd2: m_uclo = d;
      3'd3: m_uchi = d[15:0];
      3'd4: m_xuclo = d;
      3'd5: m_xuchi = d[15:0];
      3'd6: m_mclo[m_sel] = d;
      default: m_mchi[m_sel] = d[15:0];
    endcase
  endtask

  task automatic model(input logic [47:0] a, input int len,
                       output logic acc, output logic rej,
                       output logic [2:0] cls, output string tag);
    logic uc, bc, mc, hit, drop;
    int idx;
    uc = !a[0]; bc = (a == '1); mc = !uc && !bc;
    cls = {uc, bc, mc};
    drop = 1'b0; tag = "R1";
    if (!m_jumbo && !m_tag && len > 1518 && len <= 1522) begin
      drop = 1'b1; tag = "R9";
    end
    if (!drop && !m_prom) begin
      if (uc && a != {m_uchi, m_uclo}) begin drop = 1'b1; tag = "R3"; end
      if (bc && m_bcrej) begin drop = 1'b1; tag = "R4"; end
      if (mc) begin
        hit = 1'b0;
        for (int k = 0; k < 4; k++) if (a == {m_mchi[k], m_mclo[k]}) hit = 1'b1;
        if (m_mcrej || !hit) begin drop = 1'b1; tag = "R5"; end
        else tag = "R6";
      end
    end
    if (!drop && m_exta && m_extb) begin
      if (uc && a != {m_xuchi, m_xuclo}) begin drop = 1'b1; tag = "R7"; end
      if (bc && m_bcrej) begin drop = 1'b1; tag = "R4"; end
      if (mc) begin
        idx = {17'd0, a[38:32], a[47:40]};
        tag = "R8";
        if (a[23:0] == 24'h520001) drop = 1'b1;
        else if (!tbl_pat(idx >> 5)[idx % 32]) drop = 1'b1;
      end
    end
    if (!drop && len < 12) tag = "R10";
    acc = !drop && len >= 12;
    rej = !drop && len < 12;
  endtask

  task automatic send(input logic [47:0] a, input int len);
    logic acc, rej;
    logic [2:0] cls;
    string tag;
    model(a, len, acc, rej, cls, tag);
    req_valid_i = 1'b1; dest_addr_i = a; frame_len_i = 16'(len);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R2 valid", {7'd0, dec_valid_o}, 8'd1);
    chk({"R1 class ", tag}, {5'd0, ucast_o, bcast_o, mcast_o}, {5'd0, cls});
    chk({tag, " accept"}, {7'd0, accept_o}, {7'd0, acc});
    chk({tag, " reject"}, {7'd0, reject_o}, {7'd0, rej});
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] addrs [10];
    int lens [7];
    lens = '{11, 12, 64, 1518, 1519, 1522, 1523};
    m_mcrej = 0; m_bcrej = 0; m_exta = 0; m_extb = 0; m_jumbo = 0; m_tag = 0;
    m_prom = 0; m_sel = 0;
    for (int k = 0; k < 4; k++) begin m_mclo[k] = '0; m_mchi[k] = '0; end
    repeat (3) @(negedge clk_i);
    chk("R2 reset valid", {7'd0, dec_valid_o}, 8'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R2 idle", {7'd0, dec_valid_o}, 8'd0);

    // R11: reset config, zero station address matches all-zero destination
    send(48'h0, 64);
    send(48'h0, 1520);   // R9 window, reset has jumbo and tagged off
    send(48'h0, 8);      // R10

    for (int w = 0; w < 1024; w++) begin
      tbl_we_i = 1'b1; tbl_waddr_i = 10'(w); tbl_wdata_i = tbl_pat(w);
      @(negedge clk_i);
    end
    tbl_we_i = 1'b0;

    cfg_wr(3'd2, 32'h44332210); cfg_wr(3'd3, 32'hFFFF6655);
    cfg_wr(3'd4, 32'h09080706); cfg_wr(3'd5, 32'h00000B0A);
    for (int k = 3; k >= 0; k--) begin
      logic [47:0] m;
      m = mc_addr(k);
      cfg_wr(3'd1, 32'(k));
      cfg_wr(3'd6, m[31:0]);
      cfg_wr(3'd7, {16'd0, m[47:32]});
    end

    addrs[0] = 48'h6655_4433_2210;
    addrs[1] = 48'h6655_4433_2212;
    addrs[2] = 48'h0B0A_0908_0706;
    addrs[3] = '1;
    for (int k = 0; k < 4; k++) addrs[4 + k] = mc_addr(k);
    addrs[8] = {16'hBEEF, 8'h77, 24'h5E0001};
    addrs[9] = 48'hCAFE_1234_5603;

    // sweep: control bits x promiscuous x address class x length edges
    for (int c = 0; c < 64; c++) begin
      for (int p = 0; p < 2; p++) begin
        cfg_wr(3'd0, {17'd0, c[5], c[4], c[3], c[2], 8'd0, c[1], c[0], 1'b0});
        cfg_wr(3'd1, {p[0], 31'd0});
        for (int a = 0; a < 10; a++)
          for (int l = 0; l < 7; l++) send(addrs[a], lens[l]);
      end
    end

    // R6: overwrite entry 1 only, old entry 1 now drops, new one passes
    cfg_wr(3'd0, 32'd0);
    cfg_wr(3'd1, 32'd1);
    cfg_wr(3'd6, 32'h11225E01);
    cfg_wr(3'd7, 32'h00003344);
    send(mc_addr(1), 64);
    send(48'h3344_1122_5E01, 64);
    send(mc_addr(2), 64);
    // R8: walk table bits over many indices with extended stage on
    cfg_wr(3'd1, 32'h80000000);
    cfg_wr(3'd0, 32'h00001800);
    for (int i = 0; i < 400; i++)
      send({8'(i * 7), 1'b0, 7'(i * 3), 8'h9, 24'h5E0001}, 100);
    @(negedge clk_i);
    chk("R2 idle after burst", {7'd0, dec_valid_o}, 8'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule